// File: doc/BRIEF.md
# Eight-Channel TDM Sample Reader

This block takes conversion results from a multichannel delta-sigma converter whose channels all leave on one serial data line in a fixed time-division order. It watches the converter's active-low ready line and acts only on a high-to-low transition of that line. On such a transition it drives a burst of serial clocks from a divided system clock and shifts in 192 bits. It splits those bits into eight 24-bit results and tags each result with its channel number.

The serial clock stays low between bursts. Its half period is set at run time in system clocks, so the burst can finish well inside one sample period while running no faster than the converter's master clock. The block flags an overrun when a new ready edge arrives before the current burst has ended. It also drives the converter's active-low resynchronisation line. A request holds that line low for a set number of cycles, aborts any burst in progress and clears the overrun flag.

Top module: `tdm_frame_reader`

## Requirements
- R1: A burst starts only when the synchronised ready input goes from high to low. A steady low level never starts one, including the level still low after a burst ends.
- R2: Each burst gives exactly 192 rising edges on `sclk`. `sclk` is low whenever no burst is active and toggles only during a burst.
- R3: Each `sclk` high phase and low phase lasts max(`half_div`, 2) system clocks.
- R4: Each result is assembled MSB first. Bit 23 of channel 0 is the first bit on the line, and each bit is taken from the line as it stood while `sclk` was high.
- R5: Results come out as single-cycle `word_valid` pulses with `word_ch` counting 0, 1, … 7 in line order.
- R6: `frame_done` pulses for one cycle, exactly one cycle after the channel-7 result.
- R7: `overrun` is set and stays set when a ready falling edge is seen during a burst. That burst still runs to completion with all eight results.
- R8: `sync_n` is high in normal operation. A `resync_req` pulse drives it low for max(`resync_len`, 1) cycles, starting the next cycle.
- R9: A resync request ends any burst at once: `sclk` is low, no further results from that burst appear, and `overrun` is cleared. Ready edges are ignored while `sync_n` is low.
- R10: After reset, `sclk`, `word_valid`, `frame_done`, `overrun` and `busy` are low and `sync_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | 8 | `sclk` half period in system clocks (values below 2 act as 2) |
| resync_req | input | 1 | Single-cycle request to pulse `sync_n` |
| resync_len | input | 16 | Low time of `sync_n` in system clocks (0 acts as 1) |
| drdy_n | input | 1 | Converter ready line, active low, asynchronous |
| adc_data | input | 1 | Serial data from the converter, asynchronous |
| sclk | output | 1 | Serial clock to the converter |
| sync_n | output | 1 | Resynchronisation line to the converter, active low |
| word_data | output | 24 | Captured channel result |
| word_ch | output | 3 | Channel number of `word_data` |
| word_valid | output | 1 | One-cycle strobe for `word_data`/`word_ch` |
| frame_done | output | 1 | One-cycle strobe after the last channel of a burst |
| overrun | output | 1 | Sticky flag: ready edge arrived during a burst |
| busy | output | 1 | Burst in progress |

## Verification
On every cycle the assertions check that `sclk` is low and still outside a burst and that results appear only inside a burst, each right after an `sclk` high phase. They also check that `frame_done` follows the channel-7 result, that an overrun can only rise during a burst, and that a low `sync_n` leaves the block idle on the next cycle. Only the bench scenarios can show the bit order and the channel content against a model of the converter, the count of 192 clocks per burst, and the half-period length for several divider settings, including the clamp. The same holds for the abort of a half-read burst and for the exact low time of `sync_n`.

// File: rtl/tdm_rd_pkg.sv
package tdm_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rd_state_t;
endpackage

// File: rtl/tdm_in_sync.sv
// Two-stage synchroniser for one asynchronous input bit.
module tdm_in_sync #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tdm_sclk_div.sv
// Half-period timer: tick marks the last system clock of each sclk phase.
module tdm_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] cnt;

  assign half_eff = (half_div < MIN_HALF) ? MIN_HALF : half_div;
  assign tick     = run && (cnt == half_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tdm_resync.sv
// Drives the active-low resync line low for a programmed number of cycles.
module tdm_resync #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [LEN_W-1:0] len,
  output logic             sync_n
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      sync_n <= 1'b1;
    end else if (req) begin
      remain <= (len == '0) ? LEN_W'(1) : len;
      sync_n <= 1'b0;
    end else if (remain > LEN_W'(1)) begin
      remain <= remain - 1'b1;
    end else if (remain == LEN_W'(1)) begin
      remain <= '0;
      sync_n <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_shift_ctrl.sv
// Edge detection, sclk generation, shifting and channel framing.
module tdm_shift_ctrl
  import tdm_rd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 24,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              drdy_s,
  input  logic              dat_s,
  input  logic              tick,
  output logic              run,
  output logic              sclk,
  output logic [WORD_W-1:0] word_data,
  output logic [CH_W-1:0]   word_ch,
  output logic              word_valid,
  output logic              frame_done,
  output logic              overrun,
  output logic              busy
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

  rd_state_t         state;
  logic              drdy_d;
  logic              fall;
  logic [WORD_W-1:0] shreg;
  logic [BIT_W-1:0]  bit_idx;
  logic [CH_W-1:0]   ch_idx;

  assign fall = drdy_d && !drdy_s;
  assign run  = (state == ST_RUN);
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      drdy_d     <= 1'b1;
      sclk       <= 1'b0;
      shreg      <= '0;
      bit_idx    <= '0;
      ch_idx     <= '0;
      word_data  <= '0;
      word_ch    <= '0;
      word_valid <= 1'b0;
      frame_done <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      drdy_d     <= drdy_s;
      word_valid <= 1'b0;
      frame_done <= 1'b0;
      if (abort) begin
        state   <= ST_IDLE;
        sclk    <= 1'b0;
        overrun <= 1'b0;
      end else begin
        if (fall && state != ST_IDLE) overrun <= 1'b1;
        case (state)
          ST_IDLE: begin
            if (fall) begin
              state   <= ST_RUN;
              sclk    <= 1'b0;
              bit_idx <= '0;
              ch_idx  <= '0;
            end
          end
          ST_RUN: begin
            if (tick) begin
              if (!sclk) begin
                sclk <= 1'b1;
              end else begin
                // synchronised data lags two cycles: it still shows the
                // value the line held during the high phase
                sclk  <= 1'b0;
                shreg <= {shreg[WORD_W-2:0], dat_s};
                if (bit_idx == LAST_BIT) begin
                  bit_idx    <= '0;
                  word_data  <= {shreg[WORD_W-2:0], dat_s};
                  word_ch    <= ch_idx;
                  word_valid <= 1'b1;
                  ch_idx     <= ch_idx + 1'b1;
                  if (ch_idx == LAST_CH) state <= ST_DONE;
                end else begin
                  bit_idx <= bit_idx + 1'b1;
                end
              end
            end
          end
          ST_DONE: begin
            frame_done <= 1'b1;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tdm_frame_reader.sv
module tdm_frame_reader #(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8,
  parameter int RS_W   = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              resync_req,
  input  logic [RS_W-1:0]   resync_len,
  input  logic              drdy_n,
  input  logic              adc_data,
  output logic              sclk,
  output logic              sync_n,
  output logic [WORD_W-1:0] word_data,
  output logic [CH_W-1:0]   word_ch,
  output logic              word_valid,
  output logic              frame_done,
  output logic              overrun,
  output logic              busy
);
  logic drdy_s;
  logic dat_s;
  logic tick;
  logic run;
  logic abort;

  assign abort = resync_req || !sync_n;

  tdm_in_sync #(.INIT(1'b1)) drdy_sync_i (
    .clk(clk), .rst(rst), .d(drdy_n), .q(drdy_s)
  );

  tdm_in_sync #(.INIT(1'b0)) data_sync_i (
    .clk(clk), .rst(rst), .d(adc_data), .q(dat_s)
  );

  tdm_sclk_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .run(run), .half_div(half_div), .tick(tick)
  );

  tdm_resync #(.LEN_W(RS_W)) resync_i (
    .clk(clk), .rst(rst), .req(resync_req), .len(resync_len), .sync_n(sync_n)
  );

  tdm_shift_ctrl #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rst(rst), .abort(abort), .drdy_s(drdy_s), .dat_s(dat_s),
    .tick(tick), .run(run), .sclk(sclk), .word_data(word_data),
    .word_ch(word_ch), .word_valid(word_valid), .frame_done(frame_done),
    .overrun(overrun), .busy(busy)
  );
endmodule

// File: rtl/tdm_frame_reader_chk.sv
module tdm_frame_reader_chk #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            sclk,
  input logic            sync_n,
  input logic            word_valid,
  input logic [CH_W-1:0] word_ch,
  input logic            frame_done,
  input logic            overrun
);
  assert_sclk_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  assert_sclk_moves_in_burst_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> $past(busy));

  assert_word_after_high_R4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (busy && $past(sclk)));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ($past(word_valid) && $past(word_ch) == CH_W'(NUM_CH - 1)));

  assert_overrun_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(busy));

  assert_resync_idles_R9: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> !busy);
endmodule

bind tdm_frame_reader tdm_frame_reader_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .sclk(sclk), .sync_n(sync_n),
  .word_valid(word_valid), .word_ch(word_ch), .frame_done(frame_done),
  .overrun(overrun)
);

// File: tb/tdm_frame_reader_tb_top.sv
module tdm_frame_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  half_div;
  logic        resync_req;
  logic [15:0] resync_len;
  logic        drdy_n;
  logic        adc_data;
  logic        sclk, sync_n, word_valid, frame_done, overrun, busy;
  logic [23:0] word_data;
  logic [2:0]  word_ch;

  always #4 clk = ~clk;

  tdm_frame_reader dut_i (
    .clk(clk), .rst(rst), .half_div(half_div), .resync_req(resync_req),
    .resync_len(resync_len), .drdy_n(drdy_n), .adc_data(adc_data),
    .sclk(sclk), .sync_n(sync_n), .word_data(word_data), .word_ch(word_ch),
    .word_valid(word_valid), .frame_done(frame_done), .overrun(overrun),
    .busy(busy)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model: bit 0 of the burst is on the line at start,
  // the next bit follows each sclk falling edge
  logic [191:0] adc_bits = '0;
  int fall_cnt = 0;
  int base     = 0;
  int rise_cnt = 0;
  int pos;
  always @(negedge sclk) fall_cnt <= fall_cnt + 1;
  always @(posedge sclk) rise_cnt <= rise_cnt + 1;
  always_comb begin
    pos = fall_cnt - base;
    adc_data = (pos >= 0 && pos < 192) ? adc_bits[191 - pos] : 1'b0;
  end

  typedef struct { logic [2:0] ch; logic [23:0] d; } exp_t;
  exp_t q[$];
  int popped = 0;
  int hi_run = 0, last_hi = 0, lo_run = 0, last_lo = 0;
  bit prev_last = 1'b0;

  // monitor: scoreboard compare and phase-length measurement
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected word", word_data, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(word_ch == e.ch, "R5", "channel order", word_ch, e.ch);
          chk(word_data == e.d, "R4", "word data", word_data, e.d);
          popped++;
        end
      end
      if (frame_done) chk(prev_last, "R6", "done timing", 0, 1);
      prev_last = word_valid && (word_ch == 3'd7);
      if (sclk) hi_run++;
      else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
      if (!sync_n) lo_run++;
      else if (lo_run != 0) begin last_lo = lo_run; lo_run = 0; end
    end
  end

  function automatic logic [23:0] mkword(input int ch, input int seed);
    logic [31:0] x;
    if (seed == 0) return (ch[0] ? 24'hAAAAAA : 24'h555555) ^ 24'(ch);
    x = 32'(seed) * 32'h9E3779B1 + 32'(ch) * 32'h3C6EF372;
    x = x ^ (x >> 13);
    return x[23:0];
  endfunction

  int r0;

  task automatic start_frame(input int seed);
    for (int c = 0; c < 8; c++) begin
      exp_t e;
      e.ch = 3'(c);
      e.d  = mkword(c, seed);
      adc_bits[191 - c*24 -: 24] = e.d;
      q.push_back(e);
    end
    base = fall_cnt;
    r0   = rise_cnt;
    @(negedge clk) drdy_n = 1'b0;
  endtask

  task automatic wait_done();
    bit seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (frame_done) seen = 1'b1;
    end
    chk(seen, "R6", "frame_done seen", seen, 1);
  endtask

  task automatic normal_frame(input int seed, input int hd, input int exp_half);
    half_div = 8'(hd);
    start_frame(seed);
    wait_done();
    chk(rise_cnt - r0 == 192, "R2", "sclk rises", rise_cnt - r0, 192);
    chk(last_hi == exp_half, "R3", "high phase", last_hi, exp_half);
    r0 = rise_cnt;
    repeat (40) @(negedge clk);
    chk(!busy && rise_cnt == r0, "R1", "no restart on low level", busy, 0);
    drdy_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run timeout", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int rc;
    rst = 1'b1; drdy_n = 1'b1; half_div = 8'd2;
    resync_req = 1'b0; resync_len = 16'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sclk && !word_valid && !frame_done && !overrun && !busy, "R10",
        "reset outputs", {sclk, word_valid, frame_done, overrun, busy}, 0);
    chk(sync_n, "R10", "sync_n after reset", sync_n, 1);
    repeat (20) @(negedge clk);
    chk(!busy && !sclk, "R1", "idle while ready high", busy, 0);

    normal_frame(0, 2, 2);
    normal_frame(7, 5, 5);
    normal_frame(9, 0, 2);
    chk(!overrun, "R7", "no overrun on clean frames", overrun, 0);
    chk(sync_n, "R8", "sync_n high in normal use", sync_n, 1);

    // overrun: second ready edge while shifting
    half_div = 8'd3;
    start_frame(11);
    repeat (200) @(negedge clk);
    drdy_n = 1'b1;
    repeat (10) @(negedge clk);
    drdy_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(overrun && busy, "R7", "overrun set mid burst", overrun, 1);
    wait_done();
    chk(rise_cnt - r0 == 192, "R7", "overrun burst completes", rise_cnt - r0, 192);
    chk(overrun, "R7", "overrun sticky", overrun, 1);
    drdy_n = 1'b1;
    repeat (20) @(negedge clk);

    // resync aborts a half-read burst
    rc = popped;
    start_frame(13);
    for (int i = 0; i < 5000 && popped < rc + 3; i++) @(posedge clk);
    @(negedge clk);
    resync_req = 1'b1; resync_len = 16'd10;
    @(negedge clk);
    resync_req = 1'b0;
    q.delete();
    @(negedge clk);
    chk(!busy && !sclk, "R9", "burst aborted", busy, 0);
    chk(!overrun, "R9", "overrun cleared", overrun, 1'b0);
    rc = rise_cnt;
    drdy_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(rise_cnt == rc, "R9", "no sclk after abort", rise_cnt - rc, 0);
    chk(last_lo == 10, "R8", "sync_n low time", last_lo, 10);
    chk(sync_n, "R8", "sync_n released", sync_n, 1);

    resync_req = 1'b1; resync_len = 16'd0;
    @(negedge clk);
    resync_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(last_lo == 1, "R8", "zero length acts as one", last_lo, 1);

    normal_frame(21, 4, 4);
    chk(q.size() == 0, "R5", "all words delivered", q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule